// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four coil lines of a two-winding stepper motor. Each winding is fed by one pair of lines, and a line driven low energizes its coil half. A phase index walks a fixed eight-entry pattern ring. Full-step mode visits only the even entries, and in those entries both windings are on. Half-step mode visits every entry, so a single-coil state sits between each pair of two-coil states. The direction input selects whether the ring is walked forward or backward, and the ring wraps at both ends.

Steps come from one of two sources. The first is a one-cycle request pulse. The second is an internal rate timer with a programmable interval. A minimum spacing of `MIN_GAP` clock cycles is always enforced, and the default sets this spacing to 1 ms at 125 MHz. A request that arrives too early is dropped and sets a sticky overrun flag. A programmed interval shorter than the minimum is raised to the minimum. A signed position counter counts half steps. Because a full-step move made from an odd (half) phase first lands on the next even phase, the shaft position stays continuous when the mode changes. When the enable input is low, every line is released high and the sequence stays where it is.

Top module: `stepper_phase_seq`

## Requirements
- R1: After reset the phase index is 0, `coil_o` is 4'b0011 (A,B low; C,D high), `position_o` is 0 and `overrun_o` is 0.
- R2: `coil_o[3:0]` carries lines A,B,C,D from bit 3 down to bit 0, and a low level energizes a coil half. Line k (A=0..D=3) is low exactly when (index - 2k) mod 8 is 0, 6 or 7.
- R3: In full-step mode with an even index, each accepted step moves the index by 2, and exactly two lines are low in every state. The forward order is 0011, 1001, 1100, 0110 and then repeats.
- R4: In half-step mode each accepted step moves the index by 1. All eight states are visited, and the odd indices have exactly one line low.
- R5: With `dir_i`=1 the index increases, and with `dir_i`=0 it decreases. It wraps modulo 8 in both directions.
- R6: A full-step step taken from an odd index moves by 1, in the current direction, to the adjacent even index. Later steps move by 2.
- R7: `position_o` changes by +1/-1 for every index move of one and by +2/-2 for every move of two. The sign follows the direction.
- R8: A request accepted less than `MIN_GAP` cycles after the previous step is ignored and sets `overrun_o`, which stays set until reset. A request exactly `MIN_GAP` cycles after the previous step is accepted.
- R9: With `auto_i`=1, steps occur every max(`interval_i`, `MIN_GAP`) cycles, and `step_req_i` has no effect.
- R10: With `enable_i`=0, `coil_o` is 4'b1111, and no step, request or overrun takes effect. The index and position are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | 1 drives the coils, 0 releases all lines high |
| half_i | input | 1 | 1 selects half-step mode, 0 selects full-step mode |
| dir_i | input | 1 | 1 walks forward, 0 walks backward |
| auto_i | input | 1 | 1 steps from the internal rate timer |
| step_req_i | input | 1 | One-cycle step request (ignored when auto_i=1) |
| interval_i | input | IW | Auto step interval in cycles |
| coil_o | output | 4 | Coil lines A..D on bits 3..0, active low |
| position_o | output | PW | Signed half-step position |
| overrun_o | output | 1 | Sticky flag for a request that came too early |

## Verification
The assertions assume that `MIN_GAP` fits in `IW` bits and that the request is a pulse sampled on each clock edge. They also assume that mode and direction are stable at the edge that takes a step. The bench changes every input on the falling edge. It holds `interval_i` constant while the timer runs, and it changes mode and direction only between steps. Its early requests are placed deliberately, one cycle before and exactly at the minimum spacing, so that the rejection boundary is exercised.

// File: rtl/stepper_seq_pkg.sv
package stepper_seq_pkg;
  localparam int unsigned PHASES = 8;
  typedef logic [2:0] phase_t;
  typedef logic [3:0] coil_t;  // {A,B,C,D}, 0 energizes

  function automatic coil_t phase_pattern(phase_t p);
    case (p)
      3'd0: phase_pattern = 4'b0011;
      3'd1: phase_pattern = 4'b1011;
      3'd2: phase_pattern = 4'b1001;
      3'd3: phase_pattern = 4'b1101;
      3'd4: phase_pattern = 4'b1100;
      3'd5: phase_pattern = 4'b1110;
      3'd6: phase_pattern = 4'b0110;
      default: phase_pattern = 4'b0111;
    endcase
  endfunction
endpackage

// File: rtl/step_rate_gate.sv
module step_rate_gate #(
  parameter int unsigned IW      = 20,
  parameter int unsigned MIN_GAP = 125000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          auto_i,
  input  logic          req_i,
  input  logic [IW-1:0] interval_i,
  output logic          step_o,
  output logic          overrun_o
);
  localparam logic [IW-1:0] MinGap = IW'(MIN_GAP);

  logic [IW-1:0] gap_q, eff_gap;
  logic          ready_min, ready_auto, reject, overrun_q;

  // clamp the programmed interval to the minimum spacing
  assign eff_gap    = (interval_i < MinGap) ? MinGap : interval_i;
  assign ready_min  = gap_q >= MinGap;
  assign ready_auto = gap_q >= eff_gap;
  assign step_o     = enable_i & (auto_i ? ready_auto : (req_i & ready_min));
  assign reject     = enable_i & ~auto_i & req_i & ~ready_min;
  assign overrun_o  = overrun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '1;
      overrun_q <= 1'b0;
    end else begin
      if (step_o)           gap_q <= IW'(1);
      else if (gap_q != '1) gap_q <= gap_q + IW'(1);
      if (reject) overrun_q <= 1'b1;
    end
  end

  p_overrun_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_q |=> overrun_q);
  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(overrun_q));
endmodule

// File: rtl/step_phase_track.sv
module step_phase_track
  import stepper_seq_pkg::*;
#(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          half_i,
  input  logic          dir_i,
  output phase_t        phase_o,
  output logic [PW-1:0] pos_o
);
  phase_t        phase_q, delta;
  logic [PW-1:0] pos_q;

  // an odd phase in full-step mode realigns by one half step
  assign delta   = (half_i || phase_q[0]) ? 3'd1 : 3'd2;
  assign phase_o = phase_q;
  assign pos_o   = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pos_q   <= '0;
    end else if (step_i) begin
      if (dir_i) begin
        phase_q <= phase_q + delta;
        pos_q   <= pos_q + PW'(delta);
      end else begin
        phase_q <= phase_q - delta;
        pos_q   <= pos_q - PW'(delta);
      end
    end
  end

  p_full_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !half_i |=> !phase_q[0]);
  p_pos_tracks_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (pos_q[2:0] - $past(pos_q[2:0])) == (phase_q - $past(phase_q)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(phase_q) && $stable(pos_q));
  p_half_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && half_i && dir_i |=> phase_q == $past(phase_q) + 3'd1);
endmodule

// File: rtl/step_coil_decode.sv
module step_coil_decode
  import stepper_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   enable_i,
  input  phase_t phase_i,
  output coil_t  coil_o
);
  assign coil_o = enable_i ? phase_pattern(phase_i) : '1;

  p_released_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> coil_o == 4'b1111);
  p_two_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !phase_i[0] |-> $countones(~coil_o) == 2);
  p_one_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && phase_i[0] |-> $countones(~coil_o) == 1);
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
  import stepper_seq_pkg::*;
#(
  parameter int unsigned IW      = 20,
  parameter int unsigned MIN_GAP = 125000,
  parameter int unsigned PW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          half_i,
  input  logic          dir_i,
  input  logic          auto_i,
  input  logic          step_req_i,
  input  logic [IW-1:0] interval_i,
  output logic [3:0]    coil_o,
  output logic [PW-1:0] position_o,
  output logic          overrun_o
);
  logic   step;
  phase_t phase;

  step_rate_gate #(.IW(IW), .MIN_GAP(MIN_GAP)) i_gate (
    .clk_i, .rst_ni, .enable_i, .auto_i,
    .req_i      (step_req_i),
    .interval_i,
    .step_o     (step),
    .overrun_o
  );

  step_phase_track #(.PW(PW)) i_track (
    .clk_i, .rst_ni,
    .step_i  (step),
    .half_i, .dir_i,
    .phase_o (phase),
    .pos_o   (position_o)
  );

  step_coil_decode i_decode (
    .clk_i, .rst_ni, .enable_i,
    .phase_i (phase),
    .coil_o
  );

  // independent spacing monitor
  logic [IW:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_q <= '1;
    else if (step)             since_q <= (IW+1)'(1);
    else if (since_q != '1)    since_q <= since_q + 1'b1;
  end

  p_min_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> since_q >= (IW+1)'(MIN_GAP));
endmodule

// File: tb/test_stepper_phase_seq.sv
module test_stepper_phase_seq;
  localparam int IW = 6, GAP = 8, PW = 16;

  logic clk = 0, rst_n = 0;
  logic enable = 0, half = 0, dir = 1, auto_en = 0, req = 0;
  logic [IW-1:0] interval = '0;
  logic [3:0] coil;
  logic [PW-1:0] pos;
  logic overrun;

  int checks = 0, fails = 0;
  int e_idx = 0, e_pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stepper_phase_seq #(.IW(IW), .MIN_GAP(GAP), .PW(PW)) i_stepper_phase_seq (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .half_i(half), .dir_i(dir),
    .auto_i(auto_en), .step_req_i(req), .interval_i(interval),
    .coil_o(coil), .position_o(pos), .overrun_o(overrun));

  function automatic logic [3:0] exp_coil(int idx);
    logic [3:0] c = 4'b1111;
    for (int k = 0; k < 4; k++) begin
      int r = ((idx - 2*k) % 8 + 8) % 8;
      if (r == 0 || r == 6 || r == 7) c[3-k] = 1'b0;
    end
    return c;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int d = (half || (e_idx % 2 == 1)) ? 1 : 2;
    e_idx = dir ? (e_idx + d) % 8 : (e_idx - d + 8) % 8;
    e_pos = dir ? e_pos + d : e_pos - d;
  endtask

  task automatic check_state(string tag);
    check(coil == exp_coil(e_idx), tag, coil, exp_coil(e_idx));
    check($signed(pos) == e_pos, tag, $signed(pos), e_pos);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // accepted step: pulse, then wait out the spacing
  task automatic step_ok(string tag);
    req = 1; @(negedge clk); req = 0;
    model_step();
    check_state(tag);
    idle(GAP - 1);
  endtask

  initial begin
    idle(2); rst_n = 1; enable = 1; @(negedge clk);
    // R1
    check(coil == 4'b0011, "R1 coil", coil, 4'b0011);
    check(pos == 0, "R1 pos", pos, 0);
    check(overrun == 0, "R1 overrun", overrun, 0);

    // R2 R3 full forward, R5 full reverse wrap
    half = 0; dir = 1;
    for (int i = 0; i < 6; i++) step_ok("R2 R3 full fwd");
    dir = 0;
    for (int i = 0; i < 8; i++) step_ok("R3 R5 full rev");

    // R4 half both ways with wrap
    half = 1; dir = 1;
    for (int i = 0; i < 10; i++) step_ok("R4 half fwd");
    dir = 0;
    for (int i = 0; i < 11; i++) step_ok("R4 R5 half rev");

    // R6 realign from odd phase, both directions
    dir = 1; step_ok("R6 to odd");
    half = 0; step_ok("R6 realign fwd");
    check(e_idx % 2 == 0, "R6 even fwd", e_idx, 0);
    step_ok("R6 full after realign");
    half = 1; step_ok("R6 odd again");
    half = 0; dir = 0; step_ok("R6 realign rev");
    step_ok("R7 full rev pos");

    // R8 spacing boundary and sticky overrun
    half = 1; dir = 1;
    req = 1; @(negedge clk); req = 0; model_step(); check_state("R8 first");
    idle(GAP - 2);
    req = 1; @(negedge clk); req = 0;            // at GAP-1: rejected
    check_state("R8 early ignored");
    check(overrun == 1, "R8 overrun set", overrun, 1);
    req = 1; @(negedge clk); req = 0; model_step(); // at GAP: accepted
    check_state("R8 boundary accepted");
    idle(GAP + 2);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // R10 disable releases, holds, ignores
    enable = 0; @(negedge clk);
    check(coil == 4'b1111, "R10 released", coil, 4'b1111);
    req = 1; @(negedge clk); req = 0; idle(2);
    check($signed(pos) == e_pos, "R10 no step", $signed(pos), e_pos);
    enable = 1; @(negedge clk);
    check_state("R10 resumed same phase");
    idle(GAP);

    // R9 auto with clamped and long interval, request held high
    foreach (interval_sel[j]) ;
    for (int j = 0; j < 2; j++) begin
      int ival = (j == 0) ? 3 : 12;
      int expg = (j == 0) ? GAP : 12;
      int seen = 0, t = 0, last_t = 0;
      logic [PW-1:0] prev = pos;
      interval = IW'(ival); req = 1; auto_en = 1;
      while (seen < 4 && t < 200) begin
        @(negedge clk); t++;
        if (pos != prev) begin
          model_step(); seen++;
          check_state("R9 auto step");
          if (seen > 1) check(t - last_t == expg, "R9 auto spacing", t - last_t, expg);
          last_t = t; prev = pos;
        end
      end
      auto_en = 0; req = 0;
      check(seen == 4, "R9 auto ran", seen, 4);
      idle(GAP + 2);
      check_state("R9 auto stopped");
    end
    done = 1;
  end

  int interval_sel[1];

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule